// File: doc/BRIEF.md
# Multi-Channel Converter Control Register Block

This block is the digital front end of an eight-input converter. It holds a 32-bit control word and a read-only result word on a simple memory-mapped register bus. Software picks a channel, a reference and a clock divider, then sets the convert bit. The block then counts out a prescaled conversion window. When the window closes, it stores a 10-bit ratio of the chosen sample to the chosen reference and can raise an interrupt.

The analog side is modelled as digital ports. Each channel is a sample value in microvolts, and there are two references in the same unit: one internal and one external. A restoring divider computes the result while the countdown runs. A sticky interrupt flag is cleared by writing a one to it. A soft-reset bit in the control word returns the block to its power-up state.

Top module: `adc_regif`

## Requirements
- R1: The control word is at byte offset 0x0 and the result word at 0x4. A read at any other offset returns 0. Read data appears on `reg_rdata` one clock after the read access is sampled.
- R2: After reset, the control word reads 0x000C0001, the result word reads 0 and `irq` is low.
- R3: A write to offset 0x4 leaves the result word unchanged.
- R4: A conversion starts only on a control write that has enable (bit 17) at 1 and that takes the convert bit (bit 14) from 0 to 1. A convert bit written while enable is 0 is stored but starts nothing. Rewriting a convert bit that is already 1 starts nothing.
- R5: The convert bit stays 1 for exactly 40·(DIV+1) clocks after the starting write, where DIV is control bits 8:1. It then clears by itself.
- R6: The stored result is min(1023, floor(sample·1024/ref)), and a reference of 0 gives 1023. The reference is the internal one when bit 19 is 1 and the external one when it is 0. The channel, sample and reference are captured at the starting write.
- R7: The channel is control bits 27:24. A value of 8 or more still ends the conversion and clears the convert bit, but it leaves the result word unchanged and does not set the flag.
- R8: At the end of a valid conversion, the flag (bit 18) is set only if interrupt enable (bit 21) is 1. `irq` is a registered copy of flag AND interrupt enable.
- R9: A control write with bit 18 at 1 clears the flag and drops `irq` on the same edge. A write with bit 18 at 0 keeps the flag's current value.
- R10: A control write with enable 1 and convert 0 aborts a running conversion: no result is stored and no flag is set.
- R11: A control write with bit 16 at 1 sets the control word to 0x000C0001 and the result word to 0, and aborts any conversion.
- R12: The divider result is ready whenever a conversion window closes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| smp_flat | input | NUM_CH·SMP_W | Packed channel samples, channel 0 in the low bits, in microvolts |
| ref_int | input | SMP_W | Internal reference, in microvolts |
| ref_ext | input | SMP_W | External reference, in microvolts |
| irq | output | 1 | Interrupt level |

## Verification
The result path is swept over all eight channels. Each channel gets six sample levels, from zero up to above both references, and each level is converted once with each reference selection. Each channel uses a different external reference. This separates a wrong mux index, a swapped reference select and a missing clamp. Divider values 0, 1, 2, 5 and 255 check the window length at its exact edge, which catches an off-by-one in the prescaler. Directed cases cover the control paths that bypass a normal conversion: a convert bit written without enable, a convert bit rewritten while already 1, an out-of-range channel, an abort mid-window, a soft reset mid-window, and flag writes of 0 and 1.

// File: rtl/adc_regif_pkg.sv
package adc_regif_pkg;
  localparam int unsigned OFS_CTRL   = 0;
  localparam int unsigned OFS_RESULT = 4;

  localparam int unsigned CH_LSB    = 24;
  localparam int unsigned CH_W      = 4;
  localparam int unsigned IE_BIT    = 21;
  localparam int unsigned RSEL_BIT  = 19;
  localparam int unsigned FLAG_BIT  = 18;
  localparam int unsigned EN_BIT    = 17;
  localparam int unsigned SRST_BIT  = 16;
  localparam int unsigned BUSY_BIT  = 14;
  localparam int unsigned DIV_LSB   = 1;
  localparam int unsigned DIV_W     = 8;

  localparam logic [31:0] CTRL_INIT = 32'h000C_0001;

  typedef enum logic [1:0] {DV_IDLE, DV_BUSY, DV_READY} div_state_e;
endpackage

// File: rtl/adc_seq.sv
module adc_seq #(
  parameter int unsigned DIV_W = 8,
  parameter int unsigned TICKS = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             cancel,
  input  logic [DIV_W-1:0] div,
  output logic             running,
  output logic             done
);
  localparam int unsigned MAX_CYC = TICKS * 2 * (1 << DIV_W);
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] load_val;
  logic             fin;

  assign load_val = CNT_W'(2 * TICKS) * (CNT_W'(div) + CNT_W'(1)) - CNT_W'(1);
  assign fin      = running && (cnt == '0);
  assign done     = fin && !start && !cancel;

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      cnt     <= '0;
    end else if (cancel) begin
      running <= 1'b0;
    end else if (start) begin
      running <= 1'b1;
      cnt     <= load_val;
    end else if (fin) begin
      running <= 1'b0;
    end else if (running) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  // R5
  start_runs_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !cancel) |=> running);

  // R10
  cancel_stops_chk: assert property (@(posedge clk) disable iff (rst)
    cancel |=> !running);
endmodule

// File: rtl/adc_ratio_div.sv
module adc_ratio_div
  import adc_regif_pkg::*;
#(
  parameter int unsigned NUM_W = 22,
  parameter int unsigned RES_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [NUM_W-1:0] den,
  output logic [RES_W-1:0] quo,
  output logic             ready
);
  localparam int unsigned STEP_W = $clog2(RES_W + 1);
  localparam logic [RES_W-1:0] QMAX = '1;

  div_state_e        st;
  logic [NUM_W-1:0]  rem;
  logic [NUM_W-1:0]  den_q;
  logic [STEP_W-1:0] step;
  logic [NUM_W:0]    shifted;
  logic              fits;

  assign shifted = {rem, 1'b0};
  assign fits    = shifted >= {1'b0, den_q};
  assign ready   = (st == DV_READY);

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= DV_IDLE;
      rem   <= '0;
      den_q <= '0;
      step  <= '0;
      quo   <= '0;
    end else if (start) begin
      if (num >= den) begin
        quo <= QMAX;
        st  <= DV_READY;
      end else begin
        rem   <= num;
        den_q <= den;
        quo   <= '0;
        step  <= STEP_W'(RES_W);
        st    <= DV_BUSY;
      end
    end else if (st == DV_BUSY) begin
      if (fits) begin
        rem <= NUM_W'(shifted - {1'b0, den_q});
        quo <= {quo[RES_W-2:0], 1'b1};
      end else begin
        rem <= NUM_W'(shifted);
        quo <= {quo[RES_W-2:0], 1'b0};
      end
      step <= step - STEP_W'(1);
      if (step == STEP_W'(1)) st <= DV_READY;
    end
  end

  // R6
  clamp_chk: assert property (@(posedge clk) disable iff (rst)
    (start && (num >= den)) |=> (ready && quo == QMAX));
endmodule

// File: rtl/adc_regif.sv
module adc_regif
  import adc_regif_pkg::*;
#(
  parameter int unsigned NUM_CH     = 8,
  parameter int unsigned SMP_W      = 22,
  parameter int unsigned RES_W      = 10,
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned CONV_TICKS = 20
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    reg_en,
  input  logic                    reg_we,
  input  logic [ADDR_W-1:0]       reg_addr,
  input  logic [31:0]             reg_wdata,
  output logic [31:0]             reg_rdata,
  input  logic [NUM_CH*SMP_W-1:0] smp_flat,
  input  logic [SMP_W-1:0]        ref_int,
  input  logic [SMP_W-1:0]        ref_ext,
  output logic                    irq
);
  localparam int unsigned SEL_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic [SMP_W-1:0] smp_arr [NUM_CH];
  logic [31:0]      ctrl_q, ctrl_nx, wr_val;
  logic [31:0]      data_q, data_nx;
  logic             chan_ok_q;
  logic             ctrl_wr, data_wr, srst, start, cancel;
  logic             seq_running, seq_done;
  logic [CH_W-1:0]  ch_sel;
  logic             ch_ok;
  logic [SMP_W-1:0] op_num, op_den;
  logic [RES_W-1:0] div_quo;
  logic             div_ready;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_CH; gi++) begin : g_unpack
      assign smp_arr[gi] = smp_flat[gi*SMP_W +: SMP_W];
    end
  endgenerate

  assign ctrl_wr = reg_en && reg_we && (reg_addr == ADDR_W'(OFS_CTRL));
  assign data_wr = reg_en && reg_we && (reg_addr == ADDR_W'(OFS_RESULT));

  always_comb begin
    wr_val           = reg_wdata;
    wr_val[FLAG_BIT] = reg_wdata[FLAG_BIT] ? 1'b0 : ctrl_q[FLAG_BIT];
  end

  assign srst   = ctrl_wr && reg_wdata[SRST_BIT];
  assign start  = ctrl_wr && !srst && wr_val[EN_BIT] && wr_val[BUSY_BIT] && !ctrl_q[BUSY_BIT];
  assign cancel = srst || (ctrl_wr && wr_val[EN_BIT] && !wr_val[BUSY_BIT]);

  assign ch_sel = wr_val[CH_LSB +: CH_W];
  assign ch_ok  = (32'(ch_sel) < NUM_CH);
  assign op_num = ch_ok ? smp_arr[ch_sel[SEL_W-1:0]] : '0;
  assign op_den = wr_val[RSEL_BIT] ? ref_int : ref_ext;

  adc_seq #(
    .DIV_W (DIV_W),
    .TICKS (CONV_TICKS)
  ) u_seq (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .cancel  (cancel),
    .div     (wr_val[DIV_LSB +: DIV_W]),
    .running (seq_running),
    .done    (seq_done)
  );

  adc_ratio_div #(
    .NUM_W (SMP_W),
    .RES_W (RES_W)
  ) u_div (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .num   (op_num),
    .den   (op_den),
    .quo   (div_quo),
    .ready (div_ready)
  );

  always_comb begin
    ctrl_nx = ctrl_wr ? wr_val : ctrl_q;
    data_nx = data_q;
    if (srst) begin
      ctrl_nx = CTRL_INIT;
      data_nx = '0;
    end else if (seq_done) begin
      ctrl_nx[BUSY_BIT] = 1'b0;
      if (chan_ok_q) begin
        data_nx = {{(32-RES_W){1'b0}}, div_quo};
        if (ctrl_nx[IE_BIT]) ctrl_nx[FLAG_BIT] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= CTRL_INIT;
      data_q    <= '0;
      chan_ok_q <= 1'b0;
      irq       <= 1'b0;
      reg_rdata <= '0;
    end else begin
      ctrl_q <= ctrl_nx;
      data_q <= data_nx;
      irq    <= ctrl_nx[FLAG_BIT] && ctrl_nx[IE_BIT];
      if (start) chan_ok_q <= ch_ok;
      if (reg_en && !reg_we) begin
        if (reg_addr == ADDR_W'(OFS_CTRL))        reg_rdata <= ctrl_q;
        else if (reg_addr == ADDR_W'(OFS_RESULT)) reg_rdata <= data_q;
        else                                      reg_rdata <= '0;
      end
    end
  end

  // R3
  data_ro_chk: assert property (@(posedge clk) disable iff (rst)
    (data_wr && !seq_done) |=> $stable(data_q));

  // R7
  bad_chan_chk: assert property (@(posedge clk) disable iff (rst)
    (seq_done && !chan_ok_q && !ctrl_wr) |=> ($stable(data_q) && !irq));

  // R9
  w1c_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && reg_wdata[FLAG_BIT] && !reg_wdata[SRST_BIT] && !seq_done)
      |=> (!irq && !ctrl_q[FLAG_BIT]));

  // R11
  soft_rst_chk: assert property (@(posedge clk) disable iff (rst)
    srst |=> (ctrl_q == CTRL_INIT && data_q == '0 && !seq_running));

  // R12
  div_ready_chk: assert property (@(posedge clk) disable iff (rst)
    seq_done |-> div_ready);
endmodule

// File: tb/adc_regif_bench.sv
module adc_regif_bench;
  localparam int NUM_CH = 8;
  localparam int SMP_W  = 22;
  localparam int ADDR_W = 12;
  localparam int RINT   = 2000000;

  logic clk = 1'b0;
  logic rst;
  logic reg_en, reg_we;
  logic [ADDR_W-1:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic [SMP_W-1:0] smp [NUM_CH];
  logic [NUM_CH*SMP_W-1:0] smp_flat;
  logic [SMP_W-1:0] ref_int, ref_ext;
  logic irq;

  int checks = 0;
  int fails  = 0;
  int last_data = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  always_comb
    for (int i = 0; i < NUM_CH; i++) smp_flat[i*SMP_W +: SMP_W] = smp[i];

  adc_regif u_adc_regif (
    .clk(clk), .rst(rst), .reg_en(reg_en), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .smp_flat(smp_flat), .ref_int(ref_int), .ref_ext(ref_ext), .irq(irq)
  );

  task automatic check(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wait_clks(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bus_write(int addr, logic [31:0] val);
    reg_en = 1; reg_we = 1; reg_addr = ADDR_W'(addr); reg_wdata = val;
    @(posedge clk); #1;
    reg_en = 0; reg_we = 0;
  endtask

  task automatic bus_read(int addr, output logic [31:0] val);
    reg_en = 1; reg_we = 0; reg_addr = ADDR_W'(addr);
    @(posedge clk); #1;
    val = reg_rdata;
    reg_en = 0;
  endtask

  function automatic int expq(longint s, longint r);
    longint q;
    if (r == 0) return 1023;
    q = (s * 1024) / r;
    return (q > 1023) ? 1023 : int'(q);
  endfunction

  function automatic int sample_lvl(int k);
    case (k)
      0: return 0;
      1: return 100000;
      2: return 999999;
      3: return 1500000;
      4: return 2000000;
      default: return 2600000;
    endcase
  endfunction

  task automatic run_conv(int ch, int rs, int ie, int dv, string tag);
    logic [31:0] w, exp_con, rd;
    int tot, exp_d;
    exp_d = expq(smp[ch], rs ? ref_int : ref_ext);
    w = (ch << 24) | (ie << 21) | (rs << 19) | (1 << 18) | (1 << 17) | (1 << 14) | (dv << 1);
    exp_con = (ch << 24) | (ie << 21) | (rs << 19) | (ie << 18) | (1 << 17) | (dv << 1);
    tot = 40 * (dv + 1);
    bus_write(0, w);
    wait_clks(tot - 2);
    bus_read(0, rd); check({tag, " R5 busy before end"}, rd[14], 1);
    bus_read(0, rd); check({tag, " R5 busy at last cycle"}, rd[14], 1);
    bus_read(0, rd); check({tag, " R5/R8 ctrl after end"}, rd, exp_con);
    bus_read(4, rd); check({tag, " R6 result"}, rd, exp_d);
    check({tag, " R8 irq"}, irq, ie);
    last_data = exp_d;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    rst = 1; reg_en = 0; reg_we = 0; reg_addr = '0; reg_wdata = '0;
    ref_int = SMP_W'(RINT); ref_ext = SMP_W'(2200000);
    for (int i = 0; i < NUM_CH; i++) smp[i] = '0;
    wait_clks(3);
    rst = 0;
    #1;

    bus_read(0, rd);     check("R2 ctrl reset", rd, 32'h000C0001);
    bus_read(4, rd);     check("R2 result reset", rd, 0);
    check("R2 irq reset", irq, 0);
    bus_read(8, rd);     check("R1 unmapped 0x8", rd, 0);
    bus_read(12'hFFC, rd); check("R1 unmapped 0xFFC", rd, 0);

    // flag written 0 keeps the set flag; flag written 1 clears it (R9)
    bus_write(0, 32'h0008_0000);
    bus_read(0, rd);     check("R9 flag kept on write 0", rd, 32'h000C0000);
    bus_write(0, 32'h000C_0000);
    bus_read(0, rd);     check("R9 flag cleared on write 1", rd, 32'h00080000);

    // R6 sweep over channels, levels and references
    for (int ch = 0; ch < NUM_CH; ch++) begin
      ref_ext = SMP_W'(1800000 + ch * 100000);
      for (int k = 0; k < 6; k++) begin
        smp[ch] = SMP_W'(sample_lvl(k));
        for (int rs = 0; rs < 2; rs++) run_conv(ch, rs, k % 2, 0, "sweep");
      end
    end

    // R5 window length over several dividers
    smp[4] = SMP_W'(700000);
    run_conv(4, 1, 1, 1, "div1");
    run_conv(4, 0, 0, 2, "div2");
    run_conv(4, 1, 1, 5, "div5");
    run_conv(4, 0, 1, 255, "div255");

    // R6 zero reference saturates
    ref_ext = '0; smp[1] = SMP_W'(5);
    run_conv(1, 0, 0, 0, "zero ref");
    ref_ext = SMP_W'(2200000);

    // R3 result word ignores writes
    smp[6] = SMP_W'(1234567);
    run_conv(6, 1, 0, 0, "pre-R3");
    bus_write(4, 32'hFFFF_FFFF);
    bus_read(4, rd); check("R3 result after write", rd, last_data);

    // R9 via a completed conversion with interrupt enable
    run_conv(2, 1, 1, 0, "pre-R9");
    bus_write(0, (1 << 21) | (1 << 17));
    bus_read(0, rd); check("R9 flag kept", rd, (1 << 21) | (1 << 18) | (1 << 17));
    check("R9 irq kept", irq, 1);
    bus_write(0, (1 << 21) | (1 << 18) | (1 << 17));
    check("R9 irq dropped", irq, 0);
    bus_read(0, rd); check("R9 flag cleared", rd, (1 << 21) | (1 << 17));

    // R4 convert without enable starts nothing
    smp[3] = SMP_W'(333333);
    bus_write(0, (3 << 24) | (1 << 21) | (1 << 14));
    wait_clks(100);
    bus_read(0, rd); check("R4 no enable ctrl", rd, (3 << 24) | (1 << 21) | (1 << 14));
    bus_read(4, rd); check("R4 no enable result", rd, last_data);
    // R4 convert bit already 1: rewrite with enable is not an edge
    bus_write(0, (3 << 24) | (1 << 21) | (1 << 19) | (1 << 17) | (1 << 14));
    wait_clks(100);
    bus_read(0, rd); check("R4 no edge ctrl", rd, (3 << 24) | (1 << 21) | (1 << 19) | (1 << 17) | (1 << 14));
    bus_read(4, rd); check("R4 no edge result", rd, last_data);
    check("R4 no edge irq", irq, 0);
    bus_write(0, (1 << 17));

    // R7 out-of-range channel
    bus_write(0, (9 << 24) | (1 << 21) | (1 << 18) | (1 << 17) | (1 << 14));
    wait_clks(45);
    bus_read(0, rd); check("R7 ctrl", rd, (9 << 24) | (1 << 21) | (1 << 17));
    bus_read(4, rd); check("R7 result", rd, last_data);
    check("R7 irq", irq, 0);

    // R10 abort mid-window
    smp[2] = SMP_W'(50000);
    bus_write(0, (2 << 24) | (1 << 21) | (1 << 19) | (1 << 18) | (1 << 17) | (1 << 14) | (3 << 1));
    wait_clks(50);
    bus_write(0, (2 << 24) | (1 << 21) | (1 << 17));
    wait_clks(200);
    bus_read(0, rd); check("R10 ctrl", rd, (2 << 24) | (1 << 21) | (1 << 17));
    bus_read(4, rd); check("R10 result", rd, last_data);
    check("R10 irq", irq, 0);

    // R11 soft reset mid-window
    bus_write(0, (1 << 21) | (1 << 19) | (1 << 17) | (1 << 14) | (1 << 1));
    wait_clks(20);
    bus_write(0, (5 << 24) | (1 << 17) | (1 << 16));
    bus_read(0, rd); check("R11 ctrl", rd, 32'h000C0001);
    bus_read(4, rd); check("R11 result", rd, 0);
    check("R11 irq", irq, 0);
    wait_clks(100);
    bus_read(0, rd); check("R11 ctrl later", rd, 32'h000C0001);
    bus_read(4, rd); check("R11 result later", rd, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule